// File: doc/BRIEF.md
# Paged Word-Address Counter with Write Staging Buffer

This block keeps the word pointer of a 512-byte serial memory that is seen as two 256-byte pages. The bus front end hands it an 8-bit word address, and the page manager supplies the page bit. After that, every byte moved on the bus advances the pointer. Writes and reads advance it in different ways. During a write the pointer stays inside a 16-byte row and wraps at the row's end. During a read it runs through the whole 512-byte space and wraps from the top back to address zero.

Write bytes do not go straight into the array. They are collected in a 16-slot staging buffer, and each slot has a valid flag. The buffer is committed only when the front end signals STOP. The commit is a timed write cycle: it walks the slots one per clock and writes each valid slot into a single-port array. For the whole cycle the block reports busy and ignores every strobe. Bytes the front end rejects as protected still move the pointer but never become valid. A STOP with nothing staged starts no cycle. The pointer survives between transactions. A random read is a load with no data followed by reads.

Top module: `paged_addr_wbuf`

## Requirements
- R1: While reset is high and on the first cycle after it, `cur_addr` is 0, `busy` is 0 and `rd_valid` is 0.
- R2: An accepted `addr_load` sets `cur_addr` on the next cycle to {`page_sel`, `addr_byte`}, so bit 8 is the page bit and bits 7:0 are the byte. A load takes priority over a write or read strobe in the same cycle.
- R3: An accepted `wr_byte` increments only `cur_addr[3:0]`, and the row bits 8:4 stay unchanged. Offset 15 therefore wraps to offset 0 of the same row.
- R4: An accepted `rd_byte` returns the byte at the current address on `rd_data`, with `rd_valid` high, one cycle later. It also increments the full 9-bit address, and 511 wraps to 0.
- R5: The address is kept between transactions. A STOP and the write cycle it starts leave `cur_addr` unchanged.
- R6: Staged bytes reach the array only through a write cycle started by STOP. That cycle holds `busy` high for exactly WR_CYCLES clocks, and a read before STOP returns the old content.
- R7: If more than 16 bytes are written in one transaction, a later byte replaces the earlier byte at the same offset. Only the last value per offset is committed.
- R8: A byte written with `wr_keep` = 0 is not staged. The pointer still advances, and that location keeps its previous content after the commit.
- R9: A STOP when no byte is staged leaves `busy` low and writes nothing.
- R10: While `busy` is high, `addr_load`, `wr_byte`, `rd_byte` and `stop` have no effect: the address holds, there is no read response, and the write cycle does not change length.
- R11: A kept `wr_byte` in the same cycle as `stop` is staged and committed by the write cycle that this STOP starts.
- R12: An accepted `addr_load` discards any uncommitted staged bytes, so a later STOP commits nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| page_sel | input | PAGE_W | Page bit from the page manager, sampled on load |
| addr_load | input | 1 | Strobe: load the word address |
| addr_byte | input | WORD_W | Word address within the page |
| wr_byte | input | 1 | Strobe: one write data byte |
| wr_data | input | DATA_W | Write data byte |
| wr_keep | input | 1 | 1 = stage the byte, 0 = rejected as protected |
| rd_byte | input | 1 | Strobe: read one byte at the current address |
| stop | input | 1 | STOP seen on the bus |
| busy | output | 1 | Internal write cycle in progress |
| cur_addr | output | PAGE_W+WORD_W | Current word pointer (page bit on top) |
| rd_data | output | DATA_W | Read data, valid with rd_valid |
| rd_valid | output | 1 | One-cycle pulse a clock after an accepted read |

## Verification
There are two same-cycle collisions to check. The first is a data byte that arrives on the very clock in which STOP is seen. The bench drives `wr_byte` and `stop` in one cycle with nothing staged before it. It then judges the result by whether `busy` rises at all and by reading the committed byte back. The second collision is the write cycle meeting further bus strobes. The bench drives load, write and read together while `busy` is high. It requires that the address holds, that no read response appears, and that the busy window still lasts exactly WR_CYCLES clocks.

// File: rtl/pgwb_pkg.sv
package pgwb_pkg;
  localparam int unsigned DEF_PAGE_W    = 1;
  localparam int unsigned DEF_WORD_W    = 8;
  localparam int unsigned DEF_OFF_W     = 4;
  localparam int unsigned DEF_DATA_W    = 8;
  localparam int unsigned DEF_WR_CYCLES = 24;

  // what the pointer does this cycle
  typedef enum logic [1:0] {
    STEP_NONE  = 2'd0,
    STEP_LOAD  = 2'd1,
    STEP_WRITE = 2'd2,
    STEP_READ  = 2'd3
  } step_e;
endpackage

// File: rtl/pgwb_addr_ctr.sv
module pgwb_addr_ctr
  import pgwb_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int OFF_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  step_e             step,
  input  logic [ADDR_W-1:0] load_val,
  output logic [ADDR_W-1:0] addr
);
  localparam int ROW_W = ADDR_W - OFF_W;

  logic [OFF_W-1:0]  off_inc;
  logic [ROW_W-1:0]  row_cur;
  logic [ADDR_W-1:0] lin_inc;

  always_comb begin
    row_cur = addr[ADDR_W-1:OFF_W];
    off_inc = addr[OFF_W-1:0] + OFF_W'(1);
    lin_inc = addr + ADDR_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr <= '0;
    end else begin
      unique case (step)
        STEP_LOAD:  addr <= load_val;
        STEP_WRITE: addr <= {row_cur, off_inc};
        STEP_READ:  addr <= lin_inc;
        default:    addr <= addr;
      endcase
    end
  end
endmodule

// File: rtl/pgwb_wbuf.sv
module pgwb_wbuf #(
  parameter int OFF_W  = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              put,
  input  logic [OFF_W-1:0]  put_slot,
  input  logic [DATA_W-1:0] put_data,
  input  logic [OFF_W-1:0]  rd_slot,
  output logic [DATA_W-1:0] slot_data,
  output logic              slot_valid,
  output logic              any_valid
);
  localparam int SLOTS = 1 << OFF_W;

  logic [DATA_W-1:0] dat_q [SLOTS];
  logic [SLOTS-1:0]  mask_q;
  logic [SLOTS-1:0]  hit;

  for (genvar s = 0; s < SLOTS; s++) begin : g_hit
    assign hit[s] = put && (put_slot == OFF_W'(s));
  end

  always_ff @(posedge clk) begin
    if (put) dat_q[put_slot] <= put_data;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) mask_q <= '0;
    else            mask_q <= mask_q | hit;
  end

  always_comb begin
    slot_data  = dat_q[rd_slot];
    slot_valid = mask_q[rd_slot];
    any_valid  = |mask_q;
  end
endmodule

// File: rtl/pgwb_commit.sv
module pgwb_commit #(
  parameter int OFF_W     = 4,
  parameter int WR_CYCLES = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output logic             busy,
  output logic             in_copy,
  output logic             done,
  output logic [OFF_W-1:0] slot
);
  localparam int SLOTS = 1 << OFF_W;
  localparam int CNT_W = $clog2(WR_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    done    = busy && (cnt_q == CNT_W'(WR_CYCLES - 1));
    in_copy = busy && (int'(cnt_q) < SLOTS);
    slot    = cnt_q[OFF_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (!busy) begin
      cnt_q <= '0;
      if (start) busy <= 1'b1;
    end else if (done) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/pgwb_mem.sv
module pgwb_mem #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/paged_addr_wbuf.sv
module paged_addr_wbuf
  import pgwb_pkg::*;
#(
  parameter  int PAGE_W    = DEF_PAGE_W,
  parameter  int WORD_W    = DEF_WORD_W,
  parameter  int OFF_W     = DEF_OFF_W,
  parameter  int DATA_W    = DEF_DATA_W,
  parameter  int WR_CYCLES = DEF_WR_CYCLES,
  localparam int ADDR_W    = PAGE_W + WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PAGE_W-1:0] page_sel,
  input  logic              addr_load,
  input  logic [WORD_W-1:0] addr_byte,
  input  logic              wr_byte,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_keep,
  input  logic              rd_byte,
  input  logic              stop,
  output logic              busy,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  logic              ld, wr, rd, st, put, start;
  logic              any_valid, slot_valid, in_copy, done;
  logic [OFF_W-1:0]  cp_slot;
  logic [DATA_W-1:0] cp_data;
  logic [ADDR_W-1:0] cp_addr;
  step_e             step;

  // accept strobes only outside the write cycle; load > write > read
  always_comb begin
    ld    = addr_load && !busy;
    wr    = wr_byte && !busy && !addr_load;
    rd    = rd_byte && !busy && !addr_load && !wr_byte;
    st    = stop && !busy && !addr_load;
    put   = wr && wr_keep;
    start = st && (any_valid || put);
    if (ld)      step = STEP_LOAD;
    else if (wr) step = STEP_WRITE;
    else if (rd) step = STEP_READ;
    else         step = STEP_NONE;
    cp_addr = {cur_addr[ADDR_W-1:OFF_W], cp_slot};
  end

  pgwb_addr_ctr #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_ctr (
    .clk      (clk),
    .rst      (rst),
    .step     (step),
    .load_val ({page_sel, addr_byte}),
    .addr     (cur_addr)
  );

  pgwb_wbuf #(.OFF_W(OFF_W), .DATA_W(DATA_W)) u_buf (
    .clk        (clk),
    .rst        (rst),
    .clr        (ld || done),
    .put        (put),
    .put_slot   (cur_addr[OFF_W-1:0]),
    .put_data   (wr_data),
    .rd_slot    (cp_slot),
    .slot_data  (cp_data),
    .slot_valid (slot_valid),
    .any_valid  (any_valid)
  );

  pgwb_commit #(.OFF_W(OFF_W), .WR_CYCLES(WR_CYCLES)) u_cmt (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .busy    (busy),
    .in_copy (in_copy),
    .done    (done),
    .slot    (cp_slot)
  );

  pgwb_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk   (clk),
    .we    (in_copy && slot_valid),
    .waddr (cp_addr),
    .wdata (cp_data),
    .re    (rd),
    .raddr (cur_addr),
    .rdata (rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) rd_valid <= 1'b0;
    else     rd_valid <= rd;
  end
endmodule

// File: rtl/pgwb_chk.sv
module pgwb_chk #(
  parameter int PAGE_W    = 1,
  parameter int WORD_W    = 8,
  parameter int OFF_W     = 4,
  parameter int WR_CYCLES = 24,
  parameter int ADDR_W    = PAGE_W + WORD_W
) (
  input logic              clk,
  input logic              rst,
  input logic [PAGE_W-1:0] page_sel,
  input logic              addr_load,
  input logic [WORD_W-1:0] addr_byte,
  input logic              wr_byte,
  input logic              wr_keep,
  input logic              rd_byte,
  input logic              stop,
  input logic              busy,
  input logic [ADDR_W-1:0] cur_addr,
  input logic              rd_valid,
  input logic              any_valid
);
  int run_q;

  always_ff @(posedge clk) begin
    if (rst)       run_q <= 0;
    else if (busy) run_q <= run_q + 1;
    else           run_q <= 0;
  end

  a_r1_reset_idle: assert property (@(posedge clk)
    $past(rst) |-> (cur_addr == '0 && !busy && !rd_valid));

  a_r2_load: assert property (@(posedge clk) disable iff (rst)
    (addr_load && !busy) |=> cur_addr == {$past(page_sel), $past(addr_byte)});

  a_r3_write_step: assert property (@(posedge clk) disable iff (rst)
    (wr_byte && !busy && !addr_load) |=>
      (cur_addr[ADDR_W-1:OFF_W] == $past(cur_addr[ADDR_W-1:OFF_W])) &&
      (cur_addr[OFF_W-1:0] == $past(cur_addr[OFF_W-1:0]) + 1'b1));

  a_r4_read_step: assert property (@(posedge clk) disable iff (rst)
    (rd_byte && !busy && !addr_load && !wr_byte) |=>
      (cur_addr == $past(cur_addr) + 1'b1) && rd_valid);

  a_r4_valid_source: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(rd_byte && !busy));

  a_r6_busy_len: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> run_q == WR_CYCLES);

  a_r9_empty_stop: assert property (@(posedge clk) disable iff (rst)
    (stop && !busy && !addr_load && !any_valid && !(wr_byte && wr_keep)) |=> !busy);

  a_r10_frozen: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(cur_addr));
endmodule

bind paged_addr_wbuf pgwb_chk #(
  .PAGE_W(PAGE_W), .WORD_W(WORD_W), .OFF_W(OFF_W), .WR_CYCLES(WR_CYCLES)
) u_chk (
  .clk(clk), .rst(rst), .page_sel(page_sel), .addr_load(addr_load),
  .addr_byte(addr_byte), .wr_byte(wr_byte), .wr_keep(wr_keep),
  .rd_byte(rd_byte), .stop(stop), .busy(busy), .cur_addr(cur_addr),
  .rd_valid(rd_valid), .any_valid(any_valid)
);

// File: tb/tb_paged_addr_wbuf.sv
module tb_paged_addr_wbuf;
  localparam int WRC = 24;
  localparam logic [1:0] OP_LD = 2'd0, OP_WR = 2'd1, OP_RD = 2'd2, OP_ST = 2'd3;
  localparam int NV = 23;
  // {op, page, arg, expected address after op, expected read data}
  localparam logic [27:0] VEC [NV] = '{
    {OP_LD, 1'b0, 8'h10, 9'h010, 8'h00},
    {OP_WR, 1'b0, 8'hA1, 9'h011, 8'h00},
    {OP_WR, 1'b0, 8'hA2, 9'h012, 8'h00},
    {OP_ST, 1'b0, 8'h00, 9'h012, 8'h00},
    {OP_LD, 1'b0, 8'h10, 9'h010, 8'h00},
    {OP_RD, 1'b0, 8'h00, 9'h011, 8'hA1},
    {OP_RD, 1'b0, 8'h00, 9'h012, 8'hA2},
    {OP_LD, 1'b1, 8'h3E, 9'h13E, 8'h00},
    {OP_WR, 1'b0, 8'h5C, 9'h13F, 8'h00},
    {OP_WR, 1'b0, 8'h5D, 9'h130, 8'h00},
    {OP_ST, 1'b0, 8'h00, 9'h130, 8'h00},
    {OP_LD, 1'b1, 8'h3E, 9'h13E, 8'h00},
    {OP_RD, 1'b0, 8'h00, 9'h13F, 8'h5C},
    {OP_RD, 1'b0, 8'h00, 9'h140, 8'h5D},
    {OP_LD, 1'b1, 8'hFF, 9'h1FF, 8'h00},
    {OP_WR, 1'b0, 8'h77, 9'h1F0, 8'h00},
    {OP_ST, 1'b0, 8'h00, 9'h1F0, 8'h00},
    {OP_LD, 1'b0, 8'h00, 9'h000, 8'h00},
    {OP_WR, 1'b0, 8'h66, 9'h001, 8'h00},
    {OP_ST, 1'b0, 8'h00, 9'h001, 8'h00},
    {OP_LD, 1'b1, 8'hFF, 9'h1FF, 8'h00},
    {OP_RD, 1'b0, 8'h00, 9'h000, 8'h77},
    {OP_RD, 1'b0, 8'h00, 9'h001, 8'h66}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [0:0] page_sel = '0;
  logic       addr_load = 1'b0, wr_byte = 1'b0, wr_keep = 1'b0, rd_byte = 1'b0, stop = 1'b0;
  logic [7:0] addr_byte = '0, wr_data = '0;
  logic       busy, rd_valid;
  logic [8:0] cur_addr;
  logic [7:0] rd_data;

  int errs = 0;
  int total = 0;

  always #4 clk = ~clk;

  paged_addr_wbuf #(.WR_CYCLES(WRC)) dut (
    .clk(clk), .rst(rst), .page_sel(page_sel), .addr_load(addr_load),
    .addr_byte(addr_byte), .wr_byte(wr_byte), .wr_data(wr_data),
    .wr_keep(wr_keep), .rd_byte(rd_byte), .stop(stop), .busy(busy),
    .cur_addr(cur_addr), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // called at a falling edge; drives one cycle and returns at the next falling edge
  task automatic op(input bit l, input bit pg, input logic [7:0] ab, input bit w,
                    input logic [7:0] wd, input bit k, input bit r, input bit s);
    addr_load = l; page_sel = pg; addr_byte = ab;
    wr_byte = w; wr_data = wd; wr_keep = k; rd_byte = r; stop = s;
    @(negedge clk);
    addr_load = 0; wr_byte = 0; wr_keep = 0; rd_byte = 0; stop = 0;
  endtask

  task automatic t_ld(input logic [8:0] a); op(1, a[8], a[7:0], 0, 8'h0, 0, 0, 0); endtask
  task automatic t_wr(input logic [7:0] d, input bit k); op(0, 0, 8'h0, 1, d, k, 0, 0); endtask
  task automatic t_rd(); op(0, 0, 8'h0, 0, 8'h0, 0, 1, 0); endtask
  task automatic t_st(); op(0, 0, 8'h0, 0, 8'h0, 0, 0, 1); endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic fill(input logic [8:0] a, input logic [7:0] d);
    int n;
    t_ld(a); t_wr(d, 1); t_st(); wait_idle(n);
  endtask

  task automatic rd_at(input string req, input logic [8:0] a, input logic [7:0] d);
    t_ld(a); t_rd();
    chk(req, {rd_valid, rd_data}, {1'b1, d});
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, total);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++; total++;
    $display("FAIL watchdog: actual=expired expected=done");
    finish_run();
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk("R1 addr in reset", cur_addr, 0);
    chk("R1 busy in reset", busy, 0);
    rst = 0;
    @(negedge clk);
    chk("R1 after reset", {cur_addr, busy, rd_valid}, 0);

    // table walk: loads (R2), row-wrapping writes (R3), full-wrap reads (R4), stops (R5, R6)
    for (int i = 0; i < NV; i++) begin
      logic [1:0] o;
      logic       pg;
      logic [7:0] a, ed;
      logic [8:0] ea;
      {o, pg, a, ea, ed} = VEC[i];
      case (o)
        OP_LD: begin t_ld({pg, a}); chk($sformatf("R2 vec%0d", i), cur_addr, ea); end
        OP_WR: begin t_wr(a, 1);    chk($sformatf("R3 vec%0d", i), cur_addr, ea); end
        OP_RD: begin
          t_rd();
          chk($sformatf("R4 addr vec%0d", i), cur_addr, ea);
          chk($sformatf("R4 data vec%0d", i), {rd_valid, rd_data}, {1'b1, ed});
        end
        default: begin
          t_st();
          wait_idle(n);
          chk($sformatf("R6 busy length vec%0d", i), n, WRC);
          chk($sformatf("R5 addr kept vec%0d", i), cur_addr, ea);
        end
      endcase
    end

    // R6: staged byte invisible before STOP
    fill(9'h050, 8'h11);
    t_ld(9'h05F); t_wr(8'h99, 1);
    chk("R3 row wrap", cur_addr, 9'h050);
    t_rd();
    chk("R6 old data before stop", {rd_valid, rd_data}, {1'b1, 8'h11});
    t_st(); wait_idle(n);
    chk("R6 busy length", n, WRC);
    rd_at("R6 committed", 9'h05F, 8'h99);
    rd_at("R6 neighbour intact", 9'h050, 8'h11);

    // R7: 17 bytes in one row
    t_ld(9'h070);
    for (int i = 0; i < 17; i++) t_wr(8'h80 + 8'(i), 1);
    chk("R7 addr after 17", cur_addr, 9'h071);
    t_st(); wait_idle(n);
    rd_at("R7 slot0 overwritten", 9'h070, 8'h90);
    t_rd();
    chk("R7 slot1 kept", {rd_valid, rd_data}, {1'b1, 8'h81});

    // R8: rejected byte
    fill(9'h0A1, 8'h44);
    t_ld(9'h0A0); t_wr(8'h31, 1); t_wr(8'h32, 0); t_wr(8'h33, 1);
    chk("R8 addr advances", cur_addr, 9'h0A3);
    t_st(); wait_idle(n);
    rd_at("R8 kept byte", 9'h0A0, 8'h31);
    t_rd();
    chk("R8 rejected not written", {rd_valid, rd_data}, {1'b1, 8'h44});
    t_rd();
    chk("R8 later byte", {rd_valid, rd_data}, {1'b1, 8'h33});

    // R9: stop with nothing staged
    t_ld(9'h0B0); t_st();
    chk("R9 no write cycle", busy, 0);
    chk("R9 addr", cur_addr, 9'h0B0);

    // R10: strobes during busy
    t_ld(9'h0C0); t_wr(8'h12, 1); t_st();
    chk("R10 busy started", busy, 1);
    op(1, 1, 8'hEE, 1, 8'hFF, 1, 1, 1);
    chk("R10 addr held", cur_addr, 9'h0C1);
    chk("R10 no read", rd_valid, 0);
    wait_idle(n);
    chk("R10 busy length", n + 1, WRC);
    rd_at("R10 data", 9'h0C0, 8'h12);

    // R11: write and stop in the same cycle
    t_ld(9'h0D8);
    op(0, 0, 8'h0, 1, 8'h22, 1, 0, 1);
    chk("R11 busy", busy, 1);
    wait_idle(n);
    chk("R11 busy length", n, WRC);
    chk("R5 addr after cycle", cur_addr, 9'h0D9);
    rd_at("R11 committed", 9'h0D8, 8'h22);

    // R12: reload discards staged bytes
    fill(9'h0E0, 8'h01);
    t_ld(9'h0E0); t_wr(8'h55, 1); t_ld(9'h0E8); t_st();
    chk("R12 no write cycle", busy, 0);
    rd_at("R12 old data", 9'h0E0, 8'h01);

    finish_run();
  end
endmodule